// File: doc/BRIEF.md
# Synchronous Burst Pseudo-SRAM Interface

This block is the memory-side control logic of a 16-bit pseudo-static RAM that reads in fixed bursts. A read starts on a rising clock edge where chip select and the address strobe are both low. The start address is captured on that edge. After a fixed latency the block presents a fixed number of consecutive words, one per clock. A wait output tells the host when the data is valid. It is low while data is not yet available and goes high one clock before the first word.

Writes do not use the clock. When chip select is low, a word is stored on the rising edge of write-enable. Two byte-enable inputs select which halves of the word are written. If write-enable is taken low early in a read burst, the burst is cancelled. This gives a clean handover from reading to writing.

Tri-state outputs are modelled as a value plus an enable. A watchdog flags a chip-select period that lasts too long.

Top module: `psram_burst_if`

## Requirements
- R1: A burst starts on a rising clock edge when all of the following hold: chip select is low, the address strobe is low, the strobe was sampled high at the previous edge, write-enable is high, and no burst is active. That edge counts as burst edge 1 and captures the start address. Holding the strobe low over further edges does not restart the burst.
- R2: `wait_o` is low while no burst is active. It rises after burst edge LAT-1 (edge 4 by default).
- R3: Word k (k = 0..BL-1) is read from array address start+k. It is the data phase after burst edge LAT+k. `dq_oe` is high only in the data phase, and only when both chip select and output enable are low. `dq_out` is zero whenever `dq_oe` is low.
- R4: After edge LAT+BL the burst is over and `wait_o` is low again. A new burst may then start on the following edges.
- R5: A start request (a new strobe pulse with any address) during an active burst is ignored. The running burst keeps its address and timing.
- R6: The word address wraps modulo DEPTH (a power of two) within a burst.
- R7: `wait_oe` equals the inverse of chip select. A clock edge with chip select high ends any burst, and `dq_oe` is low while chip select is high.
- R8: On a rising edge of `we_n` with chip select low, the word at `addr` is written from `dq_in`. Bits 7:0 are written only when `lb_n` is low, and bits 15:8 only when `ub_n` is low. The clock plays no part in the write.
- R9: On a read, a byte lane whose enable (`ub_n` for 15:8, `lb_n` for 7:0) is high is driven as zero.
- R10: If write-enable is low on a clock edge while the burst is at edges 1..LAT-2, the burst is cancelled: `wait_o` stays low and no data follows. A start condition with write-enable low is not accepted.
- R11: `burst_err` is high once chip select has been sampled low on TMO_CYC consecutive edges. It clears on the first edge where chip select is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Burst clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| adv_n | input | 1 | Address-valid strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; a rising edge stores the word |
| ub_n | input | 1 | Upper byte enable, active low |
| lb_n | input | 1 | Lower byte enable, active low |
| addr | input | AW | Word address |
| dq_in | input | 16 | Write data |
| dq_out | output | 16 | Read data |
| dq_oe | output | 1 | Data bus drive enable |
| wait_o | output | 1 | High when data is available |
| wait_oe | output | 1 | Drive enable of the wait output |
| burst_err | output | 1 | Chip select held low too long |

## Verification
If the phase counter is wrong, it shows on `wait_o` at the edge where that output should rise or fall. It also shows as the data window moving by whole clocks. Either way, a per-clock comparison catches it within one cycle. A wrong captured address, wrong wrap or wrong lane mask shows on `dq_out` in the first data word affected. A cancel or ignore rule that fails shows as an extra burst or a missing one, starting about LAT cycles later. A watchdog count that is off by one shows on `burst_err` at edge TMO_CYC.

// File: rtl/psram_burst_if.sv
module psram_burst_if #(
  parameter int DEPTH   = 16,
  parameter int LAT     = 5,
  parameter int BL      = 4,
  parameter int TMO_CYC = 625,
  localparam int AW     = $clog2(DEPTH),
  localparam int PW     = $clog2(LAT + BL),
  localparam int TW     = $clog2(TMO_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          adv_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          ub_n,
  input  logic          lb_n,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   dq_in,
  output logic [15:0]   dq_out,
  output logic          dq_oe,
  output logic          wait_o,
  output logic          wait_oe,
  output logic          burst_err
);

  localparam logic [PW-1:0] LAST   = PW'(LAT + BL - 1);
  localparam logic [PW-1:0] RDY    = PW'(LAT - 1);
  localparam logic [PW-1:0] DFIRST = PW'(LAT);
  localparam logic [PW-1:0] CUTOFF = PW'(LAT - 2);
  localparam logic [TW-1:0] TMAX   = TW'(TMO_CYC);

  logic [15:0]   mem [DEPTH];
  logic [PW-1:0] phase;
  logic [AW-1:0] base;
  logic          adv_q;
  logic [TW-1:0] wd;

  logic          idle, start, dphase;
  logic [AW-1:0] rd_addr;
  logic [15:0]   word;

  assign idle    = (phase == '0);
  assign start   = idle && !adv_n && adv_q && we_n;
  assign dphase  = (phase >= DFIRST);
  assign rd_addr = base + AW'(phase - DFIRST);
  assign word    = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      base  <= '0;
      adv_q <= 1'b1;
      wd    <= '0;
    end else begin
      adv_q <= adv_n;
      if (cs_n)              wd <= '0;
      else if (wd != TMAX)   wd <= wd + 1'b1;

      if (cs_n) begin
        phase <= '0;
      end else if (idle) begin
        if (start) begin
          phase <= PW'(1);
          base  <= addr;
        end
      end else if (!we_n && phase <= CUTOFF) begin
        phase <= '0;
      end else if (phase == LAST) begin
        phase <= '0;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  always_ff @(posedge we_n) begin
    if (!cs_n) begin
      if (!lb_n) mem[addr][7:0]  <= dq_in[7:0];
      if (!ub_n) mem[addr][15:8] <= dq_in[15:8];
    end
  end

  assign dq_oe     = !cs_n && !oe_n && dphase;
  assign dq_out    = dq_oe ? {ub_n ? 8'h00 : word[15:8], lb_n ? 8'h00 : word[7:0]} : 16'h0000;
  assign wait_o    = (phase >= RDY);
  assign wait_oe   = !cs_n;
  assign burst_err = (wd == TMAX);

endmodule

// File: rtl/psram_burst_if_chk.sv
module psram_burst_if_chk #(
  parameter int TMO_CYC = 625
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_n,
  input logic        oe_n,
  input logic        ub_n,
  input logic        lb_n,
  input logic [15:0] dq_out,
  input logic        dq_oe,
  input logic        wait_o,
  input logic        wait_oe,
  input logic        burst_err
);

  int low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             low_cnt <= 0;
    else if (cs_n)          low_cnt <= 0;
    else if (low_cnt < TMO_CYC) low_cnt <= low_cnt + 1;
  end

  assert_wait_before_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> wait_o);

  assert_data_follows_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(wait_o) && !cs_n) ##1 (!cs_n && !oe_n) |-> dq_oe);

  assert_quiet_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> dq_out == 16'h0000);

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (!dq_oe && !wait_oe));

  assert_upper_lane_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && ub_n) |-> dq_out[15:8] == 8'h00);

  assert_lower_lane_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && lb_n) |-> dq_out[7:0] == 8'h00);

  assert_watchdog_R11: assert property (@(posedge clk) disable iff (!rst_n)
    burst_err == (low_cnt >= TMO_CYC));

endmodule

bind psram_burst_if psram_burst_if_chk #(.TMO_CYC(TMO_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .ub_n(ub_n), .lb_n(lb_n),
  .dq_out(dq_out), .dq_oe(dq_oe), .wait_o(wait_o), .wait_oe(wait_oe),
  .burst_err(burst_err)
);

// File: tb/psram_burst_if_tb.sv
module psram_burst_if_tb;
  localparam int DEPTH = 16, LAT = 5, BL = 4, TMO = 625, AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, adv_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, ub_n = 1'b0, lb_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0] dq_in = '0;
  logic [15:0] dq_out;
  logic dq_oe, wait_o, wait_oe, burst_err;

  always #2 clk = ~clk;

  psram_burst_if #(.DEPTH(DEPTH), .LAT(LAT), .BL(BL), .TMO_CYC(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .adv_n(adv_n), .oe_n(oe_n), .we_n(we_n),
    .ub_n(ub_n), .lb_n(lb_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
    .dq_oe(dq_oe), .wait_o(wait_o), .wait_oe(wait_oe), .burst_err(burst_err));

  int checks = 0, errors = 0;
  string cur_req = "R7";
  bit done = 1'b0;

  // behavioural reference
  int rc = 0, base = 0, wd = 0;
  bit advq = 1'b1;
  logic [15:0] rmem [DEPTH];

  initial for (int i = 0; i < DEPTH; i++) rmem[i] = 16'h0000;

  always @(posedge clk) begin
    if (!rst_n) begin
      rc = 0; base = 0; wd = 0; advq = 1'b1;
    end else begin
      if (cs_n) rc = 0;
      else if (rc == 0) begin
        if (!adv_n && advq && we_n) begin rc = 1; base = int'(addr); end
      end
      else if (!we_n && rc <= LAT - 2) rc = 0;
      else if (rc == LAT + BL - 1) rc = 0;
      else rc = rc + 1;
      advq = adv_n;
      if (cs_n) wd = 0;
      else if (wd < TMO) wd = wd + 1;
    end
  end

  always @(posedge we_n) begin
    if (!cs_n) begin
      if (!lb_n) rmem[addr][7:0]  = dq_in[7:0];
      if (!ub_n) rmem[addr][15:8] = dq_in[15:8];
    end
  end

  task automatic cmp(input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      logic dp, e_oe;
      logic [15:0] w, e_out;
      dp    = (rc >= LAT);
      e_oe  = !cs_n && !oe_n && dp;
      w     = rmem[(base + rc - LAT) % DEPTH];
      e_out = e_oe ? {ub_n ? 8'h00 : w[15:8], lb_n ? 8'h00 : w[7:0]} : 16'h0000;
      cmp("wait_o R2",    {15'd0, wait_o},    {15'd0, rc >= LAT - 1});
      cmp("wait_oe R7",   {15'd0, wait_oe},   {15'd0, !cs_n});
      cmp("dq_oe R3",     {15'd0, dq_oe},     {15'd0, e_oe});
      cmp("dq_out R3",    dq_out,             e_out);
      cmp("burst_err R11", {15'd0, burst_err}, {15'd0, wd >= TMO});
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input int a, input logic [15:0] d, input logic u, input logic l);
    cs_n = 1'b0; adv_n = 1'b1; we_n = 1'b0; addr = AW'(a); dq_in = d; ub_n = u; lb_n = l;
    step();
    we_n = 1'b1;
    step();
    cs_n = 1'b1; ub_n = 1'b0; lb_n = 1'b0;
    step();
  endtask

  // start strobe for adv_cycles edges, then hold cs low for hold more edges
  task automatic rd(input int a, input int adv_cycles, input int hold);
    cs_n = 1'b0; oe_n = 1'b0; adv_n = 1'b0; addr = AW'(a);
    step(adv_cycles);
    adv_n = 1'b1; addr = '0;
    step(hold);
  endtask

  task automatic idle_cs();
    cs_n = 1'b1; oe_n = 1'b1; adv_n = 1'b1;
    step(2);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);

    cur_req = "R8";
    for (int i = 0; i < DEPTH; i++) wr(i, 16'hA000 + 16'(i * 16'h0111), 1'b0, 1'b0);

    cur_req = "R1"; rd(2, 1, 11); idle_cs();
    cur_req = "R1"; rd(5, 3, 10); idle_cs();
    cur_req = "R6"; rd(14, 1, 10); idle_cs();

    cur_req = "R3";
    cs_n = 1'b0; oe_n = 1'b0; adv_n = 1'b0; addr = 4'd7; step();
    adv_n = 1'b1; step(4); oe_n = 1'b1; step(2); oe_n = 1'b0; step(4);
    idle_cs();

    cur_req = "R5";
    cs_n = 1'b0; oe_n = 1'b0; adv_n = 1'b0; addr = 4'd1; step();
    adv_n = 1'b1; step(2); adv_n = 1'b0; addr = 4'd9; step();
    adv_n = 1'b1; step(2); adv_n = 1'b0; addr = 4'd12; step();
    adv_n = 1'b1; step(5);
    idle_cs();

    cur_req = "R4";
    cs_n = 1'b0; oe_n = 1'b0; adv_n = 1'b0; addr = 4'd3; step();
    adv_n = 1'b1; step(8); adv_n = 1'b0; addr = 4'd10; step();
    adv_n = 1'b1; step(10);
    idle_cs();

    cur_req = "R7";
    rd(4, 1, 5); cs_n = 1'b1; step(2);
    rd(6, 1, 10); idle_cs();

    cur_req = "R9";
    ub_n = 1'b1; rd(0, 1, 10); idle_cs();
    ub_n = 1'b0; lb_n = 1'b1; rd(8, 1, 10); idle_cs(); lb_n = 1'b0;

    cur_req = "R8";
    wr(6, 16'h1234, 1'b1, 1'b0);
    wr(7, 16'h5678, 1'b0, 1'b1);
    rd(5, 1, 10); idle_cs();

    cur_req = "R10";
    cs_n = 1'b0; oe_n = 1'b0; adv_n = 1'b0; addr = 4'd2; step();
    adv_n = 1'b1; addr = 4'd11; dq_in = 16'hBEEF; step();
    we_n = 1'b0; step(); we_n = 1'b1; step(9);
    idle_cs();
    cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b0; adv_n = 1'b0; addr = 4'd3; dq_in = 16'hC0DE; step();
    adv_n = 1'b1; we_n = 1'b1; step(9);
    idle_cs();
    rd(11, 1, 10); idle_cs();

    cur_req = "R11";
    cs_n = 1'b0; step(TMO + 20);
    cs_n = 1'b1; step(3);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    errors++;
    done = 1'b1;
    $display("FAIL watchdog: run did not complete, actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule